// File: doc/BRIEF.md
# PLL Control Register Bank

This block is a byte-wide register bank that sits on a simple peripheral bus. It holds the settings that software gives a phase-locked loop and reports the loop's status. Software selects a register with a small address and uses a write strobe with a data byte to change it. A read strobe returns the selected register on a combinational read path. The bank holds a 12-bit feedback multiplier, which is split over a high byte and a low byte. It also holds a control byte with three bits: an automatic-bandwidth enable, a bandwidth mode bit (acquisition or tracking) and a lock flag.

While automatic bandwidth control is off, software owns the mode bit and drives the loop's mode directly. While it is on, the loop reports its own mode and the bit becomes read-only. The value software wrote last is kept aside and drives the mode again as soon as automatic control is switched off. The lock flag comes from an asynchronous status pin through a two-stage synchronizer. The multiplier reaches the loop only when its low byte is written, so a two-byte update appears at the output in one step.

Top module: `pll_regbank`

## Requirements
- R1: After reset the high multiplier register reads 0x00, the low register reads 0x02, the control register reads 0x00, `mult_out` is 0x002 and `track_out` is 0 (acquisition).
- R2: Address 0 is the high multiplier register: bits 3:0 hold multiplier bits 11:8, and bits 7:4 read 0 and ignore writes. Address 1 is the low register (multiplier bits 7:0). Address 2 is the control register: bit 7 is the automatic enable, bit 6 is the lock flag and bit 5 is the mode (0 = acquisition, 1 = tracking). All other control bits read 0.
- R3: While the automatic enable is 0, a write to control bit 5 sets the mode. The mode reads back at bit 5 and drives `track_out` from the cycle after the write.
- R4: While the automatic enable is 1, control bit 5 and `track_out` follow `acq_status_in`, and writes to bit 5 are ignored.
- R5: The last mode value written while manual is kept through automatic operation. It drives `track_out` again on the cycle after the automatic enable is cleared. A write that sets the automatic enable while the bank is still manual also stores its bit 5.
- R6: The lock flag equals `lock_in` delayed by two clock edges. Writes to it have no effect.
- R7: `mult_out` changes only on a write to the low register. It then becomes {high[3:0], written byte}. A write to the high register alone leaves `mult_out` unchanged.
- R8: Address 3 reads 0x00 and ignores writes. `rd_data` is 0x00 whenever `rd_en` is 0.
- R9: While the automatic enable is 0, `acq_status_in` has no effect on the mode bit or on `track_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read byte (combinational) |
| lock_in | input | 1 | Asynchronous lock indication from the PLL |
| acq_status_in | input | 1 | Mode reported by the PLL in automatic mode (1 = tracking) |
| auto_en_out | output | 1 | Automatic bandwidth enable to the PLL |
| track_out | output | 1 | Bandwidth mode to the PLL (1 = tracking) |
| mult_out | output | 12 | Committed feedback multiplier |

## Verification
A corrupted shadow bit stays hidden while automatic control is on. It surfaces on `track_out` and on control bit 5 in the first cycle after the enable drops. For that reason the bench always reads the mode back right after leaving automatic mode, with both stored values 0 and 1. A staging error in the multiplier shows on `mult_out` one edge after the low-byte write, or too early after a high-byte write, so `mult_out` is sampled after every write. A synchronizer of the wrong depth moves the lock flag by one cycle, and the flag is sampled after each edge.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int MULT_W   = 12;
    localparam int MHI_W    = MULT_W - DATA_W;
    localparam int SYNC_LEN = 2;

    localparam logic [ADDR_W-1:0] OFF_MHI  = 2'd0;
    localparam logic [ADDR_W-1:0] OFF_MLO  = 2'd1;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 2'd2;

    localparam int BIT_AUTO = 7;
    localparam int BIT_LOCK = 6;
    localparam int BIT_MODE = 5;

    localparam logic [MULT_W-1:0] MULT_RST = 12'h002;

    typedef enum logic [1:0] {
        SEL_MHI  = 2'd0,
        SEL_MLO  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic auto_en;
        logic lock;
        logic mode;
    } ctrl_view_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_MHI:  return SEL_MHI;
            OFF_MLO:  return SEL_MLO;
            OFF_CTRL: return SEL_CTRL;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_view_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[BIT_AUTO] = c.auto_en;
        b[BIT_LOCK] = c.lock;
        b[BIT_MODE] = c.mode;
        return b;
    endfunction
endpackage

// File: rtl/pllreg_sync.sv
module pllreg_sync #(
    parameter int STAGES = pllreg_pkg::SYNC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pllreg_mode.sv
module pllreg_mode (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_we,
    input  logic wr_auto,
    input  logic wr_mode,
    input  logic acq_status_in,
    output logic auto_en,
    output logic mode_eff
);
    logic sw_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_en <= 1'b0;
            sw_mode <= 1'b0;
        end else if (ctrl_we) begin
            auto_en <= wr_auto;
            // the software value is only taken while software owns the bit
            if (!auto_en) begin
                sw_mode <= wr_mode;
            end
        end
    end

    always_comb begin
        mode_eff = auto_en ? acq_status_in : sw_mode;
    end
endmodule

// File: rtl/pllreg_mult.sv
module pllreg_mult
    import pllreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [MHI_W-1:0]  hi_q,
    output logic [DATA_W-1:0] lo_q,
    output logic [MULT_W-1:0] mult_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= MULT_RST[MULT_W-1:DATA_W];
            lo_q   <= MULT_RST[DATA_W-1:0];
            mult_q <= MULT_RST;
        end else begin
            if (hi_we) begin
                hi_q <= wdata[MHI_W-1:0];
            end
            if (lo_we) begin
                lo_q   <= wdata;
                mult_q <= {hi_q, wdata};
            end
        end
    end
endmodule

// File: rtl/pll_regbank.sv
module pll_regbank
    import pllreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              lock_in,
    input  logic              acq_status_in,
    output logic              auto_en_out,
    output logic              track_out,
    output logic [MULT_W-1:0] mult_out
);
    reg_sel_e          sel;
    logic              lock_sync;
    logic              auto_q;
    logic              mode_q;
    logic [MHI_W-1:0]  mhi_q;
    logic [DATA_W-1:0] mlo_q;
    ctrl_view_t        ctrl_v;

    assign sel = decode_sel(addr);

    pllreg_sync #(.STAGES(SYNC_LEN)) u_lock_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(lock_in),
        .q_sync (lock_sync)
    );

    pllreg_mode u_mode (
        .clk          (clk),
        .rst          (rst),
        .ctrl_we      (wr_en && sel == SEL_CTRL),
        .wr_auto      (wr_data[BIT_AUTO]),
        .wr_mode      (wr_data[BIT_MODE]),
        .acq_status_in(acq_status_in),
        .auto_en      (auto_q),
        .mode_eff     (mode_q)
    );

    pllreg_mult u_mult (
        .clk   (clk),
        .rst   (rst),
        .hi_we (wr_en && sel == SEL_MHI),
        .lo_we (wr_en && sel == SEL_MLO),
        .wdata (wr_data),
        .hi_q  (mhi_q),
        .lo_q  (mlo_q),
        .mult_q(mult_out)
    );

    always_comb begin
        ctrl_v.auto_en = auto_q;
        ctrl_v.lock    = lock_sync;
        ctrl_v.mode    = mode_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (sel)
                SEL_MHI:  rd_data = {{(DATA_W-MHI_W){1'b0}}, mhi_q};
                SEL_MLO:  rd_data = mlo_q;
                SEL_CTRL: rd_data = pack_ctrl(ctrl_v);
                default:  rd_data = '0;
            endcase
        end
    end

    assign auto_en_out = auto_q;
    assign track_out   = mode_q;
endmodule

// File: rtl/pll_regbank_chk.sv
module pll_regbank_chk
    import pllreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              lock_in,
    input logic              acq_status_in,
    input logic              auto_en_out,
    input logic              track_out,
    input logic [MULT_W-1:0] mult_out,
    input logic              lock_q
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    a_r7_mult_only_on_low: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OFF_MLO) |=> $stable(mult_out));

    a_r9_manual_mode_held: assert property (@(posedge clk) disable iff (rst)
        (!auto_en_out && !(wr_en && addr == OFF_CTRL)) |=> $stable(track_out));

    a_r4_auto_follows_pll: assert property (@(posedge clk) disable iff (rst)
        (auto_en_out && rd_en && addr == OFF_CTRL) |-> rd_data[BIT_MODE] == acq_status_in);

    a_r2_high_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFF_MHI) |-> rd_data[7:4] == 4'h0);

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || addr == 2'd3) |-> rd_data == '0);

    a_r6_lock_two_stage: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> lock_q == $past(lock_in, 2));
endmodule

bind pll_regbank pll_regbank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .lock_in      (lock_in),
    .acq_status_in(acq_status_in),
    .auto_en_out  (auto_en_out),
    .track_out    (track_out),
    .mult_out     (mult_out),
    .lock_q       (lock_sync)
);

// File: tb/tb_pll_regbank.sv
module tb_pll_regbank;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  addr;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic        lock_in;
    logic        acq_status_in;
    logic        auto_en_out;
    logic        track_out;
    logic [11:0] mult_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pll_regbank dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .lock_in(lock_in),
        .acq_status_in(acq_status_in), .auto_en_out(auto_en_out),
        .track_out(track_out), .mult_out(mult_out)
    );

    // vector: [30:29] addr, [28:21] write byte, [20] acq_status_in,
    //         [19:12] expected read of same addr, [11:0] expected mult_out
    localparam int NVEC = 10;
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 8'hF5, 1'b0, 8'h05, 12'h002},  // R2 upper nibble dropped, R7 no commit
        {1'b0, 2'd1, 8'h3C, 1'b0, 8'h3C, 12'h53C},  // R7 commit on low
        {1'b0, 2'd2, 8'h20, 1'b0, 8'h20, 12'h53C},  // R3 manual tracking
        {1'b0, 2'd2, 8'hA0, 1'b0, 8'h80, 12'h53C},  // R4 auto, pll says acquisition
        {1'b0, 2'd2, 8'h80, 1'b1, 8'hA0, 12'h53C},  // R4 auto, pll says tracking
        {1'b0, 2'd2, 8'h00, 1'b1, 8'h20, 12'h53C},  // R5 shadow 1 restored
        {1'b0, 2'd3, 8'hFF, 1'b0, 8'h00, 12'h53C},  // R8 unmapped
        {1'b0, 2'd0, 8'h0A, 1'b0, 8'h0A, 12'h53C},  // R7 high alone
        {1'b0, 2'd1, 8'hFF, 1'b0, 8'hFF, 12'hAFF},  // R7 commit
        {1'b0, 2'd2, 8'h00, 1'b1, 8'h00, 12'hAFF}   // R9 manual ignores pll
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rd_data;
        rd_en = 1'b0;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        lock_in = 1'b0; acq_status_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, r); check("R1 high", r, 8'h00);
        rd(2'd1, r); check("R1 low", r, 8'h02);
        rd(2'd2, r); check("R1 ctrl", r, 8'h00);
        check("R1 mult_out", mult_out, 12'h002);
        check("R1 track_out", track_out, 1'b0);

        // R8 read strobe low
        addr = 2'd1; rd_en = 1'b0; #1;
        check("R8 rd_en low", rd_data, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            v = VEC[i];
            acq_status_in = v[20];
            wr(v[30:29], v[28:21]);
            rd(v[30:29], r);
            check($sformatf("R2/R3/R4/R5/R7/R8/R9 vec%0d rd", i), r, v[19:12]);
            check($sformatf("R7 vec%0d mult", i), mult_out, v[11:0]);
        end

        // R3 track_out in manual
        acq_status_in = 1'b1;
        wr(2'd2, 8'h20);
        check("R3 track_out manual", track_out, 1'b1);
        // R5 with shadow 0: store 0, enter auto, leave
        wr(2'd2, 8'h00);
        check("R9 track_out ignores pll", track_out, 1'b0);
        wr(2'd2, 8'h80);
        check("R4 track_out auto", track_out, 1'b1);
        wr(2'd2, 8'hA0);
        check("R4 auto_en_out", auto_en_out, 1'b1);
        wr(2'd2, 8'h00);
        check("R5 shadow 0 restored", track_out, 1'b0);
        rd(2'd2, r); check("R5 ctrl after leave", r, 8'h00);

        // R6 lock synchronizer depth and write immunity
        @(negedge clk);
        lock_in = 1'b1;
        @(negedge clk);
        rd(2'd2, r); check("R6 lock after 1 edge", r[6], 1'b0);
        @(negedge clk);
        rd(2'd2, r); check("R6 lock after 2 edges", r[6], 1'b1);
        wr(2'd2, 8'h00);
        rd(2'd2, r); check("R6 lock ignores write", r, 8'h40);
        lock_in = 1'b0;
        wr(2'd2, 8'h40);
        @(negedge clk);
        rd(2'd2, r); check("R6 write 1 ignored", r, 8'h00);

        // R1 reset again clears everything
        lock_in = 1'b1;
        wr(2'd2, 8'hA0);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd2, r); check("R1 ctrl after reset", r, 8'h00);
        check("R1 mult after reset", mult_out, 12'h002);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule